// File: doc/BRIEF.md
# Frame Start Detector

This block decides the moment a serial frame begins in one direction (receive or transmit) of a synchronous serial port. It watches a selected start condition: free-running, the other direction's start, a level or transition on the synchronized frame-sync line, or a compare-match pulse from the sync-data comparator. Once the condition is seen, it counts a programmable number of bit clocks and then emits a single-cycle start pulse that tells the shifter to begin with the first data bit.

The frame then stays open until the shifter reports the end of the data, or, in compare mode with the stop option, until a second compare match arrives. Conditions that come up while a frame is pending or open have no effect. Alongside this, a period divider produces an internal frame trigger at a fixed spacing in bit clocks, which a neighbouring frame-sync generator can use. All decisions are taken on cycles where the bit-clock enable is high. The block shifts no data itself.

Top module: `frame_start_detect`

## Requirements
- R1: After reset, `start_pulse`, `in_frame` and `period_trig` are all low.
- R2: With `start_sel` 2 a low `fsync` sample starts a frame, and with `start_sel` 3 a high sample does.
- R3: With `start_sel` 4 a 1-to-0 change between the previous and the current `fsync` sample starts a frame, with 5 a 0-to-1 change does, and with 6 or 7 a change in either direction does.
- R4: A transition only counts once a sample has been taken since `enable` rose; the first sample after enabling never produces an edge start.
- R5: With `start_dly` = N, `start_pulse` follows the bit-clock edge N bit clocks after the one where the condition was seen; with N = 0 it follows that same edge. The pulse is high for the clock cycle right after that edge.
- R6: With `start_sel` 1 a `peer_start` pulse starts a frame.
- R7: With `start_sel` 0 a frame starts on every bit clock where the block is idle and a word is available (`word_ready` high, or `hold_for_word` low), so a new frame begins on the bit clock right after the previous one ends.
- R8: With `start_sel` 8 the first frame waits for `cmp0_hit`; when `stop_on_cmp` is low, later frames then start as in R7 until `enable` drops.
- R9: With `start_sel` 8 and `stop_on_cmp` high, a frame also ends on `cmp1_hit`, and the next frame again waits for `cmp0_hit`.
- R10: `in_frame` is high from the start pulse until the bit clock where the frame ends (`frame_done`). Start conditions seen while the delay counts or a frame is open are ignored.
- R11: Dropping `enable` cancels a pending delay or open frame, with no start pulse following. `start_sel` codes 9 to 15 never start a frame.
- R12: With `period` = P not zero, `period_trig` pulses every 2×(P+1) bit clocks, the first one 2×(P+1) bit clocks after enabling; with P = 0 it stays low.
- R13: Inputs act only on cycles where `bit_en` is high, and `start_pulse` never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Direction enable; low cancels everything |
| bit_en | input | 1 | One-cycle strobe per bit clock |
| start_sel | input | 4 | Start condition code (0 to 8, others reserved) |
| start_dly | input | DLY_W | Bit clocks from condition to start |
| period | input | PER_W | Internal trigger period field; 0 turns it off |
| stop_on_cmp | input | 1 | In compare mode, end frames on compare 1 |
| hold_for_word | input | 1 | Continuous starts wait for `word_ready` |
| word_ready | input | 1 | A data word is available |
| fsync | input | 1 | Synchronized frame-sync line |
| peer_start | input | 1 | Start pulse of the other direction |
| cmp0_hit | input | 1 | Sync data matched compare value 0 |
| cmp1_hit | input | 1 | Sync data matched compare value 1 |
| frame_done | input | 1 | The shifter finished the frame's data |
| start_pulse | output | 1 | One-cycle start of data |
| in_frame | output | 1 | A frame is open |
| period_trig | output | 1 | One-cycle internal frame trigger |

## Verification
The hardest situation to reach from the ports is a transition on `fsync` that falls while a start delay is still counting, or while a frame is open. Such a transition has to be ignored, but it must not look like an edge at the next idle sample either. The stimulus fixes the bit-clock strobe to a known cadence and changes `fsync` on chosen strobes inside the delay window and inside an open frame. It then checks that the only start pulses come on the predicted strobe numbers. A similar sequence drops `enable` in the middle of a delay, and another raises `fsync` in the very cycle that enables the block, to show that edge detection waits for a first sample.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_ACTIVE = 2'd2
    } phase_e;

    // start condition codes
    localparam logic [SEL_W-1:0] SEL_CONT = 4'd0;
    localparam logic [SEL_W-1:0] SEL_PEER = 4'd1;
    localparam logic [SEL_W-1:0] SEL_LOW  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_HIGH = 4'd3;
    localparam logic [SEL_W-1:0] SEL_FALL = 4'd4;
    localparam logic [SEL_W-1:0] SEL_RISE = 4'd5;
    localparam logic [SEL_W-1:0] SEL_CHG  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_EDGE = 4'd7;
    localparam logic [SEL_W-1:0] SEL_CMP  = 4'd8;

endpackage

// File: rtl/fsd_fs_track.sv
// Keeps the previous bit-clock sample of the frame-sync line and whether
// one sample has been taken since the direction was enabled.
module fsd_fs_track (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_en,
    input  logic fsync,
    output logic fs_prev,
    output logic fs_seen
);
    typedef struct packed {
        logic prev;
        logic seen;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (bit_en) begin
            trk_d.prev = fsync;
        end
        trk_d.seen = enable && (trk_q.seen || bit_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign fs_prev = trk_q.prev;
    assign fs_seen = trk_q.seen;
endmodule

// File: rtl/fsd_cond_mux.sv
// Evaluates the selected start condition for the current bit clock.
module fsd_cond_mux
    import fsd_pkg::*;
(
    input  logic [SEL_W-1:0] start_sel,
    input  logic             fsync,
    input  logic             fs_prev,
    input  logic             fs_seen,
    input  logic             peer_start,
    input  logic             cmp0_hit,
    input  logic             cmp_latched,
    input  logic             word_ok,
    output logic             cond_hit
);
    logic changed;

    assign changed = fs_seen && (fs_prev != fsync);

    always_comb begin
        unique case (start_sel)
            SEL_CONT: cond_hit = word_ok;
            SEL_PEER: cond_hit = peer_start;
            SEL_LOW:  cond_hit = !fsync;
            SEL_HIGH: cond_hit = fsync;
            SEL_FALL: cond_hit = changed && !fsync;
            SEL_RISE: cond_hit = changed && fsync;
            SEL_CHG:  cond_hit = changed;
            SEL_EDGE: cond_hit = changed;
            SEL_CMP:  cond_hit = cmp_latched ? word_ok : cmp0_hit;
            default:  cond_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsd_period_gen.sv
// Internal frame trigger: one pulse every 2*(period+1) bit clocks.
module fsd_period_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_en,
    input  logic [PER_W-1:0] period,
    output logic             period_trig
);
    localparam int CW = PER_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          trig;
    } per_t;

    per_t per_d, per_q;
    logic [CW-1:0] last_cnt;

    // 2*period+1 is the period field with a one appended
    assign last_cnt = {period, 1'b1};

    always_comb begin
        per_d      = per_q;
        per_d.trig = 1'b0;
        if (!enable || period == '0) begin
            per_d.cnt = '0;
        end else if (bit_en) begin
            if (per_q.cnt == last_cnt) begin
                per_d.cnt  = '0;
                per_d.trig = 1'b1;
            end else begin
                per_d.cnt = per_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
        end else begin
            per_q <= per_d;
        end
    end

    assign period_trig = per_q.trig;
endmodule

// File: rtl/frame_start_detect.sv
module frame_start_detect
    import fsd_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_en,
    input  logic [SEL_W-1:0] start_sel,
    input  logic [DLY_W-1:0] start_dly,
    input  logic [PER_W-1:0] period,
    input  logic             stop_on_cmp,
    input  logic             hold_for_word,
    input  logic             word_ready,
    input  logic             fsync,
    input  logic             peer_start,
    input  logic             cmp0_hit,
    input  logic             cmp1_hit,
    input  logic             frame_done,
    output logic             start_pulse,
    output logic             in_frame,
    output logic             period_trig
);
    typedef struct packed {
        phase_e           ph;
        logic [DLY_W-1:0] cnt;
        logic             start;
        logic             cmp_latch;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic fs_prev, fs_seen;
    logic word_ok, cond_hit, frame_end;

    fsd_fs_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .bit_en  (bit_en),
        .fsync   (fsync),
        .fs_prev (fs_prev),
        .fs_seen (fs_seen)
    );

    assign word_ok = !hold_for_word || word_ready;

    fsd_cond_mux u_cond (
        .start_sel   (start_sel),
        .fsync       (fsync),
        .fs_prev     (fs_prev),
        .fs_seen     (fs_seen),
        .peer_start  (peer_start),
        .cmp0_hit    (cmp0_hit),
        .cmp_latched (ctl_q.cmp_latch),
        .word_ok     (word_ok),
        .cond_hit    (cond_hit)
    );

    fsd_period_gen #(.PER_W(PER_W)) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .bit_en      (bit_en),
        .period      (period),
        .period_trig (period_trig)
    );

    // a frame closes on the shifter's report, or on compare 1 in stop mode
    assign frame_end = frame_done ||
                       (start_sel == SEL_CMP && stop_on_cmp && cmp1_hit);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        if (!enable) begin
            ctl_d.ph        = PH_IDLE;
            ctl_d.cnt       = '0;
            ctl_d.cmp_latch = 1'b0;
        end else if (bit_en) begin
            unique case (ctl_q.ph)
                PH_IDLE: begin
                    if (cond_hit) begin
                        if (start_sel == SEL_CMP && !stop_on_cmp) begin
                            ctl_d.cmp_latch = 1'b1;
                        end
                        if (start_dly == '0) begin
                            ctl_d.start = 1'b1;
                            ctl_d.ph    = PH_ACTIVE;
                        end else begin
                            ctl_d.cnt = start_dly;
                            ctl_d.ph  = PH_DELAY;
                        end
                    end
                end
                PH_DELAY: begin
                    if (ctl_q.cnt == DLY_W'(1)) begin
                        ctl_d.start = 1'b1;
                        ctl_d.ph    = PH_ACTIVE;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - DLY_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (frame_end) begin
                        ctl_d.ph = PH_IDLE;
                    end
                end
                default: ctl_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, cnt: '0, start: 1'b0, cmp_latch: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_pulse = ctl_q.start;
    assign in_frame    = (ctl_q.ph == PH_ACTIVE);
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             bit_en,
    input logic [PER_W-1:0] period,
    input logic             start_pulse,
    input logic             in_frame,
    input logic             period_trig
);
    assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_on_bit_clock_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bit_en));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !$past(in_frame));

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_pulse && !in_frame && !period_trig));

    assert_period_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        period_trig |-> ($past(period) != '0 && $past(bit_en) && $past(enable)));

    assert_open_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> in_frame);
endmodule

bind frame_start_detect fsd_checker #(.PER_W(PER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .bit_en      (bit_en),
    .period      (period),
    .start_pulse (start_pulse),
    .in_frame    (in_frame),
    .period_trig (period_trig)
);

// File: tb/frame_start_detect_test.sv
`timescale 1ns/1ps
module frame_start_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] start_sel = '0;
    logic [7:0] start_dly = '0;
    logic [7:0] period = '0;
    logic       stop_on_cmp = 1'b0;
    logic       hold_for_word = 1'b0;
    logic       word_ready = 1'b0;
    logic       fsync = 1'b0;
    logic       peer_start = 1'b0;
    logic       cmp0_hit = 1'b0;
    logic       cmp1_hit = 1'b0;
    logic       frame_done = 1'b0;
    logic       start_pulse, in_frame, period_trig;

    frame_start_detect uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
        .start_sel(start_sel), .start_dly(start_dly), .period(period),
        .stop_on_cmp(stop_on_cmp), .hold_for_word(hold_for_word),
        .word_ready(word_ready), .fsync(fsync), .peer_start(peer_start),
        .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit), .frame_done(frame_done),
        .start_pulse(start_pulse), .in_frame(in_frame), .period_trig(period_trig)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int be_cnt = 0;
    int start_seen = 0;
    int ph = 0;
    int exp_q[$];
    string exp_tag[$];
    int per_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // bit clock strobe: one cycle in four
    always @(negedge clk) begin
        ph = (ph + 1) % 4;
        bit_en = (ph == 0);
    end

    always @(posedge clk) if (bit_en) be_cnt++;

    // monitor: compares start and trigger pulses against the expected strobe numbers
    always @(negedge clk) begin : mon
        int k;
        string t;
        if (rst_n && start_pulse) begin
            start_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected start", be_cnt, -1);
            end else begin
                k = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(be_cnt == k, t, be_cnt, k);
            end
        end
        if (rst_n && period_trig) begin
            if (per_q.size() == 0) begin
                check(1'b0, "R12 unexpected trigger", be_cnt, -1);
            end else begin
                k = per_q.pop_front();
                check(be_cnt == k, "R12", be_cnt, k);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!bit_en) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_start(input int k, input string tag);
        exp_q.push_back(k);
        exp_tag.push_back(tag);
    endtask

    task automatic end_frame();
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        check(in_frame == 1'b0, "R10 frame closed", in_frame, 0);
    endtask

    task automatic expect_none(input int n, input string tag);
        int n0;
        n0 = start_seen;
        step(n);
        check(start_seen == n0, tag, start_seen - n0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : drive
        int c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_pulse == 0 && in_frame == 0 && period_trig == 0, "R1 reset",
              {start_pulse, in_frame, period_trig}, 0);
        expect_none(2, "R11 disabled idle");

        // R4 then R3: rising edge, no delay
        start_sel = 4'd5; fsync = 1'b0;
        step(2);
        enable = 1'b1; fsync = 1'b1;
        expect_none(3, "R4 first sample");
        fsync = 1'b0; step(1);
        c = be_cnt; fsync = 1'b1; expect_start(c + 1, "R3 rise");
        step(1);
        check(in_frame == 1'b1, "R10 open", in_frame, 1);
        fsync = 1'b0; step(1); fsync = 1'b1; step(1);
        end_frame();
        enable = 1'b0; step(1);

        // R5: falling edge, three bit clocks of delay, edges inside ignored
        start_sel = 4'd4; start_dly = 8'd3; fsync = 1'b1; step(1);
        enable = 1'b1; step(1);
        c = be_cnt; fsync = 1'b0; expect_start(c + 4, "R5 delay 3");
        step(1); fsync = 1'b1; step(1); fsync = 1'b0; step(1);
        check(in_frame == 1'b0, "R5 still delaying", in_frame, 0);
        step(1);
        check(in_frame == 1'b1, "R5 open after delay", in_frame, 1);
        end_frame();
        enable = 1'b0; start_dly = 8'd0; step(1);

        // R2: level starts
        start_sel = 4'd3; fsync = 1'b1; step(1);
        c = be_cnt; enable = 1'b1; expect_start(c + 1, "R2 high");
        step(1); fsync = 1'b0; end_frame();
        enable = 1'b0; step(1);
        start_sel = 4'd2; fsync = 1'b0;
        c = be_cnt; enable = 1'b1; expect_start(c + 1, "R2 low");
        step(1); fsync = 1'b1; end_frame();
        enable = 1'b0; step(1);

        // R3: any change (6) both ways, any edge (7)
        start_sel = 4'd6; fsync = 1'b0; enable = 1'b1; step(1);
        c = be_cnt; fsync = 1'b1; expect_start(c + 1, "R3 change up");
        step(1); end_frame();
        c = be_cnt; fsync = 1'b0; expect_start(c + 1, "R3 change down");
        step(1); end_frame();
        enable = 1'b0; step(1);
        start_sel = 4'd7; enable = 1'b1; step(1);
        c = be_cnt; fsync = 1'b1; expect_start(c + 1, "R3 any edge");
        step(1); end_frame();
        enable = 1'b0; fsync = 1'b0; step(1);

        // R6: peer start, repeated peer inside the frame ignored (R10)
        start_sel = 4'd1; enable = 1'b1; step(1);
        c = be_cnt; peer_start = 1'b1; expect_start(c + 1, "R6 peer");
        step(1); step(1); peer_start = 1'b0;
        end_frame();
        enable = 1'b0; step(1);

        // R7: continuous with word gating
        start_sel = 4'd0; hold_for_word = 1'b1; word_ready = 1'b0; enable = 1'b1;
        expect_none(3, "R7 waits for word");
        c = be_cnt; word_ready = 1'b1; expect_start(c + 1, "R7 word arrives");
        step(1);
        c = be_cnt; expect_start(c + 2, "R7 back to back");
        end_frame(); step(1);
        word_ready = 1'b0; end_frame();
        expect_none(3, "R7 no word");
        enable = 1'b0; step(1);
        hold_for_word = 1'b0;
        c = be_cnt; enable = 1'b1; expect_start(c + 1, "R7 ungated");
        step(1);
        enable = 1'b0; step(1);
        check(in_frame == 1'b0, "R11 disable closes frame", in_frame, 0);

        // R8: compare start, then continuous
        start_sel = 4'd8; stop_on_cmp = 1'b0; enable = 1'b1;
        expect_none(2, "R8 waits for compare");
        c = be_cnt; cmp0_hit = 1'b1; expect_start(c + 1, "R8 compare 0");
        step(1); cmp0_hit = 1'b0;
        c = be_cnt; expect_start(c + 2, "R8 latched continuous");
        end_frame(); step(1);
        enable = 1'b0; step(1);

        // R9: stop on compare 1, rearm on compare 0
        stop_on_cmp = 1'b1; enable = 1'b1; step(1);
        c = be_cnt; cmp0_hit = 1'b1; expect_start(c + 1, "R9 compare 0");
        step(1); cmp0_hit = 1'b0;
        cmp1_hit = 1'b1; step(1); cmp1_hit = 1'b0;
        check(in_frame == 1'b0, "R9 compare 1 ends", in_frame, 0);
        expect_none(3, "R9 rearmed");
        c = be_cnt; cmp0_hit = 1'b1; expect_start(c + 1, "R9 compare 0 again");
        step(1); cmp0_hit = 1'b0;
        end_frame();
        enable = 1'b0; stop_on_cmp = 1'b0; step(1);

        // R11: reserved code never starts
        start_sel = 4'd9; enable = 1'b1; word_ready = 1'b1;
        fsync = 1'b1; peer_start = 1'b1; cmp0_hit = 1'b1; step(1);
        fsync = 1'b0; step(1); fsync = 1'b1;
        expect_none(2, "R11 reserved code");
        fsync = 1'b0; peer_start = 1'b0; cmp0_hit = 1'b0; word_ready = 1'b0;
        enable = 1'b0; step(1);

        // R11: disable during delay cancels the start
        start_sel = 4'd3; fsync = 1'b1; start_dly = 8'd5; enable = 1'b1;
        step(2); enable = 1'b0; step(1);
        check(in_frame == 1'b0, "R11 abort delay", in_frame, 0);
        expect_none(6, "R11 no late start");
        start_dly = 8'd0; fsync = 1'b0;

        // R12: period trigger
        start_sel = 4'd9; period = 8'd2;
        c = be_cnt; enable = 1'b1;
        per_q.push_back(c + 6); per_q.push_back(c + 12); per_q.push_back(c + 18);
        step(20);
        enable = 1'b0; step(1);
        check(per_q.size() == 0, "R12 trigger count", per_q.size(), 0);
        period = 8'd0; enable = 1'b1; step(20); enable = 1'b0; step(1);

        check(exp_q.size() == 0, "R5 pending starts", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule